// File: doc/BRIEF.md
# Serial Flash Write-Enable Latch Front End

This block is the command front end of a serial flash slave. It holds the latch that allows writes. While chip select is low, it shifts the serial data input in on each rising serial clock edge and assembles the first byte of the frame as an opcode, most significant bit first. Two opcodes act on the latch: 06h sets it and 04h clears it. The change is committed only when chip select is released, and only if the frame ended on a whole byte.

The block also classifies the modify-type commands (program, erase, protection, lockdown, one-time-programmable write, status and configuration register writes). The handlers for those commands use the latch output and the inhibit output to decide whether to run. Each time chip select is released, the block gives a one-cycle pulse with a two-bit verdict on the frame. All pins are synchronised into one system clock.

The controller has three states:
- `ST_IDLE`: waiting for chip select to fall.
- `ST_OPCODE`: shifting in the opcode byte.
- `ST_TAIL`: opcode complete; later bits are counted and ignored.

Transitions:
- `ST_IDLE` to `ST_OPCODE` on a chip-select fall.
- `ST_OPCODE` to `ST_TAIL` on the eighth bit.
- `ST_OPCODE` to `ST_IDLE` on a chip-select rise (early release, aborted).
- `ST_TAIL` to `ST_IDLE` on a chip-select rise (verdict issued).

Top module: `spi_wel_front`

## Requirements
- R1: After reset, `wel` is 0, `write_inhibit` is 1 and `frame_done` is low.
- R2: Data is sampled on rising `sck` edges while `cs_n` is low, most significant bit first. Opcode 06h sets `wel` to 1 at `cs_n` release and reports status 2'b00 (accepted).
- R3: Opcode 04h clears `wel` to 0 at `cs_n` release and reports status 2'b00.
- R4: `wel` does not change while `cs_n` is still low, even after the eighth opcode bit has arrived.
- R5: Bits clocked in after the opcode byte do not alter the decoded opcode. For example, 04h followed by the byte 06h still clears `wel`.
- R6: Releasing `cs_n` before eight bits have arrived (including zero bits) reports status 2'b01 (aborted) and leaves `wel` unchanged.
- R7: Releasing `cs_n` when the total bit count is eight or more but not a multiple of eight reports 2'b01 and leaves `wel` unchanged.
- R8: A whole-byte frame whose opcode is neither a latch opcode nor a modify opcode reports 2'b10 (unrecognised) and leaves `wel` unchanged.
- R9: The following are modify opcodes: 02h, 20h, 52h, D8h, 60h, C7h, 36h, 39h, 33h, 34h, 9Bh, 01h, 31h.
  - With `wel` at 0, a modify frame reports 2'b11 (blocked).
  - With `wel` at 1, a modify frame reports 2'b00.
  - In both cases `wel` is unchanged.
  - `write_inhibit` always equals the inverse of `wel`.
- R10: Every `cs_n` release that follows a `cs_n` fall gives exactly one `frame_done` pulse of one clock cycle.
- R11: A new `cs_n` fall restarts the bit count and the opcode. A frame that follows an aborted one is decoded on its own bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock pin |
| cs_n | input | 1 | Chip select pin, active low |
| si | input | 1 | Serial data input pin |
| wel | output | 1 | Write-enable latch |
| write_inhibit | output | 1 | High while modify commands must be blocked |
| frame_done | output | 1 | One-cycle pulse after each `cs_n` release |
| frame_status | output | 2 | Frame verdict: 00 accepted, 01 aborted, 10 unrecognised, 11 blocked |

## Verification
An internal fault shows up at the ports about four system clocks after the `cs_n` release that follows the faulty frame:
- A bit counter that slips shows as a wrong abort or accept verdict.
- A shift register that keeps capturing past the opcode byte shows as a wrong opcode verdict, or a `wel` value set the wrong way after a frame with trailing data.
- A premature commit shows as `wel` moving while `cs_n` is still low, so the bench samples `wel` before releasing the select.
- A stuck state shows as a missing or doubled `frame_done` pulse.

// File: rtl/spi_wel_pkg.sv
package spi_wel_pkg;

    localparam int OP_BITS = 8;
    localparam int CNT_W   = $clog2(OP_BITS);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OPCODE = 2'd1,
        ST_TAIL   = 2'd2
    } wel_state_e;

    typedef enum logic [1:0] {
        FS_ACCEPT  = 2'b00,
        FS_ABORT   = 2'b01,
        FS_UNKNOWN = 2'b10,
        FS_BLOCKED = 2'b11
    } frame_status_e;

    localparam logic [OP_BITS-1:0] OP_LATCH_SET = 8'h06;
    localparam logic [OP_BITS-1:0] OP_LATCH_CLR = 8'h04;

    function automatic logic is_modify_op(input logic [OP_BITS-1:0] op);
        unique case (op)
            8'h02, 8'h20, 8'h52, 8'hD8, 8'h60, 8'hC7, 8'h36,
            8'h39, 8'h33, 8'h34, 8'h9B, 8'h01, 8'h31: return 1'b1;
            default:                                   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/wel_pin_sync.sv
module wel_pin_sync #(
    parameter int               WIDTH  = 3,
    parameter int               STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] chain [STAGES];
    logic [WIDTH-1:0] prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n)
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= pins;
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n)
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) prev <= RST_VAL;
        else        prev <= chain[STAGES-1];

    assign level = chain[STAGES-1];
    assign rise  = level & ~prev;
    assign fall  = ~level & prev;
endmodule

// File: rtl/wel_frame_shift.sv
module wel_frame_shift
    import spi_wel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               bit_strobe,
    input  logic               capture,
    input  logic               si_bit,
    output logic [OP_BITS-1:0] opcode,
    output logic [CNT_W-1:0]   bit_cnt,
    output logic               byte_done
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opcode  <= '0;
            bit_cnt <= '0;
        end else if (restart) begin
            opcode  <= '0;
            bit_cnt <= '0;
        end else if (bit_strobe) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (capture) opcode <= {opcode[OP_BITS-2:0], si_bit};
        end
    end

    assign byte_done = bit_strobe && capture && (bit_cnt == CNT_W'(OP_BITS-1));
endmodule

// File: rtl/spi_wel_front.sv
module spi_wel_front
    import spi_wel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       si,
    output logic       wel,
    output logic       write_inhibit,
    output logic       frame_done,
    output logic [1:0] frame_status
);
    // pin order in the synchroniser bus: {cs_n, sck, si}
    logic [2:0] p_level, p_rise, p_fall;

    wel_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pins ({cs_n, sck, si}),
        .level(p_level),
        .rise (p_rise),
        .fall (p_fall)
    );

    logic cs_fall, cs_rise, sck_rise, si_s;
    assign cs_fall  = p_fall[2];
    assign cs_rise  = p_rise[2];
    assign sck_rise = p_rise[1];
    assign si_s     = p_level[0];

    wel_state_e state, state_nx;

    logic [OP_BITS-1:0] opcode;
    logic [CNT_W-1:0]   bit_cnt;
    logic               byte_done;

    wel_frame_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (state == ST_IDLE && cs_fall),
        .bit_strobe(sck_rise && state != ST_IDLE),
        .capture   (state == ST_OPCODE),
        .si_bit    (si_s),
        .opcode    (opcode),
        .bit_cnt   (bit_cnt),
        .byte_done (byte_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (cs_fall) state_nx = ST_OPCODE;
            ST_OPCODE: if (cs_rise) state_nx = ST_IDLE;
                       else if (byte_done) state_nx = ST_TAIL;
            ST_TAIL:   if (cs_rise) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs: latch, pulse and verdict
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel          <= 1'b0;
            frame_done   <= 1'b0;
            frame_status <= FS_ACCEPT;
        end else begin
            frame_done <= 1'b0;
            if (state != ST_IDLE && cs_rise) begin
                frame_done <= 1'b1;
                if (state == ST_OPCODE || bit_cnt != '0) begin
                    frame_status <= FS_ABORT;
                end else if (opcode == OP_LATCH_SET) begin
                    wel          <= 1'b1;
                    frame_status <= FS_ACCEPT;
                end else if (opcode == OP_LATCH_CLR) begin
                    wel          <= 1'b0;
                    frame_status <= FS_ACCEPT;
                end else if (is_modify_op(opcode)) begin
                    frame_status <= wel ? FS_ACCEPT : FS_BLOCKED;
                end else begin
                    frame_status <= FS_UNKNOWN;
                end
            end
        end
    end

    assign write_inhibit = ~wel;
endmodule

// File: rtl/spi_wel_front_chk.sv
module spi_wel_front_chk
    import spi_wel_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wel,
    input logic       write_inhibit,
    input logic       frame_done,
    input logic [1:0] frame_status
);
    // R4: the latch moves only together with a frame verdict
    assert_commit_at_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wel != $past(wel)) |-> frame_done);

    // R6 / R7: an aborted frame leaves the latch alone
    assert_abort_keeps_wel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && frame_status == FS_ABORT) |-> (wel == $past(wel)));

    // R8: an unrecognised opcode leaves the latch alone
    assert_unknown_keeps_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && frame_status == FS_UNKNOWN) |-> (wel == $past(wel)));

    // R9: a blocked verdict is only possible with the latch clear
    assert_blocked_needs_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && frame_status == FS_BLOCKED) |-> (!wel && !$past(wel)));

    // R10: the verdict pulse lasts one cycle
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R9: inhibit mirrors the latch
    always_comb if (rst_n) assert_inhibit_R9: assert (write_inhibit == !wel);
endmodule

bind spi_wel_front spi_wel_front_chk u_chk (.*);

// File: tb/spi_wel_front_bench.sv
module spi_wel_front_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic wel, write_inhibit, frame_done;
    logic [1:0] frame_status;

    int checks = 0, errors = 0, pulses = 0;
    logic [1:0] last_st = 2'b00;

    always #5 clk = ~clk;

    spi_wel_front u_spi_wel_front (.*);

    always @(negedge clk) if (frame_done) begin
        pulses++;
        last_st = frame_status;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic open_frame();
        cs_n = 1'b0; wait_n(4);
    endtask

    task automatic shift_bits(input logic [31:0] d, input int n);
        for (int i = 0; i < n; i++) begin
            si = d[n-1-i]; wait_n(4);
            sck = 1'b1;    wait_n(4);
            sck = 1'b0;
        end
        wait_n(4);
    endtask

    task automatic close_frame();
        cs_n = 1'b1; wait_n(10);
    endtask

    // run one frame and check pulse count, verdict and latch
    task automatic frame(input logic [31:0] d, input int n, input logic [1:0] exp_st,
                         input logic exp_wel, input string req);
        int p0 = pulses;
        open_frame(); shift_bits(d, n); close_frame();
        chk(pulses == p0 + 1, {req, " pulse"}, pulses - p0, 1);
        chk(last_st == exp_st, {req, " status"}, last_st, exp_st);
        chk(wel == exp_wel, {req, " wel"}, wel, exp_wel);
        chk(write_inhibit == !exp_wel, {req, " inhibit"}, write_inhibit, !exp_wel);
    endtask

    task automatic t_reset();
        chk(wel == 1'b0, "R1 wel", wel, 0);
        chk(write_inhibit == 1'b1, "R1 inhibit", write_inhibit, 1);
        chk(pulses == 0, "R1 no pulse", pulses, 0);
    endtask

    task automatic t_set_clear();
        frame(32'h06, 8, 2'b00, 1'b1, "R2 set");
        frame(32'h04, 8, 2'b00, 1'b0, "R3 clear");
    endtask

    task automatic t_commit_late();
        int p0 = pulses;
        open_frame(); shift_bits(32'h06, 8);
        chk(wel == 1'b0, "R4 wel before release", wel, 0);
        chk(pulses == p0, "R4 no early pulse", pulses - p0, 0);
        close_frame();
        chk(wel == 1'b1, "R4 wel after release", wel, 1);
    endtask

    task automatic t_trailing();
        frame(32'h0406, 16, 2'b00, 1'b0, "R5 trailing ignored");
        frame(32'h06_04_04, 24, 2'b00, 1'b1, "R5 set with tail");
    endtask

    task automatic t_abort();
        frame(32'h2, 3, 2'b01, 1'b1, "R6 short frame");
        frame(32'h0, 0, 2'b01, 1'b1, "R6 empty frame");
        frame(32'h04_5, 11, 2'b01, 1'b1, "R7 odd length");
        frame(32'h04, 8, 2'b00, 1'b0, "R11 fresh frame after abort");
    endtask

    task automatic t_unknown();
        frame(32'h05, 8, 2'b10, 1'b0, "R8 unknown");
        frame(32'h9F, 8, 2'b10, 1'b0, "R8 unknown 2");
    endtask

    task automatic t_modify();
        frame(32'h02_000000, 32, 2'b11, 1'b0, "R9 program blocked");
        frame(32'hD8, 8, 2'b11, 1'b0, "R9 erase blocked");
        frame(32'h06, 8, 2'b00, 1'b1, "R9 enable");
        frame(32'h20_0000, 24, 2'b00, 1'b1, "R9 erase allowed");
        frame(32'h31, 8, 2'b00, 1'b1, "R9 config allowed");
    endtask

    task automatic t_pulse_count();
        int p0 = pulses;
        for (int k = 0; k < 3; k++) begin
            open_frame(); shift_bits(32'h05, 8); close_frame();
        end
        chk(pulses == p0 + 3, "R10 pulse per release", pulses - p0, 3);
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(4);
        t_reset();
        t_set_clear();
        t_commit_late();
        t_trailing();
        t_abort();
        t_unknown();
        t_modify();
        t_pulse_count();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule